// File: doc/BRIEF.md
# Flash Command Launch and Status Register

This block sits between a bus register port and a flash command execution engine. Software starts a command by writing 1 to the completion flag of the status register. The block accepts the launch only if neither sticky error flag is set. It then pulses a start strobe to the engine and tracks the command until the engine reports completion or a violation. While a command runs, the completion flag reads 0 and a busy flag reads 1.

The status register also holds two sticky write-1-to-clear error flags and a two-bit completion status. The access-error flag is set by the engine. The protection-violation flag is set by an input pulse. The completion status accumulates the status bits that the engine returns. A second register holds single-fault and double-fault detect flags, each set by an input pulse and cleared by writing 1.

Command tracking is a two-state machine. `ST_IDLE` is the state with no command in flight. `ST_RUN` is the state with a command executing. The transition LAUNCH goes from `ST_IDLE` to `ST_RUN` on an accepted launch write. The transition FINISH goes from `ST_RUN` back to `ST_IDLE` when the engine asserts done or error. Every other condition holds the current state.

Top module: `flash_cmd_stat`

## Requirements
- R1: After reset, the status register (offset 6) reads 0x80, with the completion flag (bit 7) at 1 and all other bits at 0. The fault register (offset 7) reads 0x00, and the start strobe is 0.
- R2: A write to offset 6 with bit 7 = 1, made while idle with bits 5 and 4 clear, is an accepted launch. From the next cycle bit 7 reads 0 and bit 3 reads 1. The start strobe is high for exactly that one cycle, and bits 1:0 are cleared.
- R3: While running, an engine done pulse returns bit 7 to 1 and bit 3 to 0. The engine status bits presented with done are ORed into bits 1:0.
- R4: While running, an engine error pulse ends the command (bit 7 back to 1) and sets the access-error flag, bit 5.
- R5: While bit 5 is set, a launch write neither clears bit 7 nor raises the start strobe.
- R6: A protection-violation input pulse sets bit 4. While bit 4 is set, a launch write is refused.
- R7: Writing 1 to bit 5 or bit 4 clears that flag, and writing 0 leaves it unchanged. When one write sets bit 7 together with an error bit, the error is cleared but the launch is judged on the error state held before that write, so it is refused.
- R8: Bit 3 (busy) always reads the inverse of bit 7.
- R9: A launch write while a command is running issues no second start strobe. An engine done pulse while idle changes nothing.
- R10: Bits 6 and 2 always read 0, and bits 1:0 cannot be changed by a bus write.
- R11: In the fault register, bit 0 is the single-fault flag and bit 1 the double-fault flag. Each is set by its input pulse and cleared by writing 1 to it. Bits 7:2 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on reg_addr) |
| eng_start | output | 1 | One-cycle command start strobe to the engine |
| eng_done | input | 1 | Engine command-completed pulse |
| eng_err | input | 1 | Engine illegal-command or sequence-violation pulse |
| eng_stat | input | 2 | Completion status bits, valid with eng_done |
| prot_viol | input | 1 | Protection-violation pulse |
| fault_single | input | 1 | Single-fault detect pulse |
| fault_double | input | 1 | Double-fault detect pulse |

## Verification
Launches are tried in four situations: a clean launch, a launch with the access-error flag set, a launch with the protection-violation flag set, and a combined write of the launch bit with an error-clear bit. Together these separate a launch gate that reads the old flag state from one that reads the new state. Commands are ended both by done, with several status values, and by error. This shows whether the status bits accumulate and whether they are cleared at launch. Stray stimulus is also applied: launch writes during a run, done while idle, zero writes to sticky flags, and writes to reserved or read-only bits. The state visible at the ports is read back after each.

// File: rtl/flcs_pkg.sv
package flcs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cmd_state_e;

    localparam int DATA_W    = 8;
    localparam int BIT_DONE  = 7;
    localparam int BIT_ACCER = 5;
    localparam int BIT_PROT  = 4;
    localparam int BIT_BUSY  = 3;
    localparam int BIT_DFLT  = 1;
    localparam int BIT_SFLT  = 0;
endpackage

// File: rtl/flcs_w1c_flag.sv
module flcs_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // A set pulse wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end

    assert_set_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/flcs_cmd_fsm.sv
module flcs_cmd_fsm
    import flcs_pkg::*;
#(
    parameter int ST_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch_req_i,
    input  logic            blocked_i,
    input  logic            eng_done_i,
    input  logic            eng_err_i,
    input  logic [ST_W-1:0] eng_stat_i,
    output logic            idle_o,
    output logic            start_o,
    output logic            acc_set_o,
    output logic [ST_W-1:0] stat_o
);
    cmd_state_e state_q, state_d;
    logic       accept;
    logic       finish;

    assign accept = (state_q == ST_IDLE) && launch_req_i && !blocked_i;
    assign finish = (state_q == ST_RUN) && (eng_done_i || eng_err_i);

    // Transition logic: LAUNCH and FINISH.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RUN;
            ST_RUN:  if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs: start strobe and completion status.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            stat_o  <= '0;
        end else begin
            start_o <= accept;
            if (accept)
                stat_o <= '0;
            else if ((state_q == ST_RUN) && eng_done_i)
                stat_o <= stat_o | eng_stat_i;
        end
    end

    assign idle_o    = (state_q == ST_IDLE);
    assign acc_set_o = (state_q == ST_RUN) && eng_err_i;

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !idle_o);
    assert_blocked_no_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req_i && blocked_i) |=> !start_o);
    assert_finish_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && (eng_done_i || eng_err_i)) |=> idle_o);
    assert_run_relaunch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && !eng_done_i && !eng_err_i) |=> (!idle_o && !start_o));
endmodule

// File: rtl/flcs_fault_reg.sv
module flcs_fault_reg #(
    parameter int N_FLT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_FLT-1:0] set_i,
    input  logic [N_FLT-1:0] clr_i,
    output logic [N_FLT-1:0] q_o
);
    for (genvar i = 0; i < N_FLT; i++) begin : g_flt
        flcs_w1c_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_i[i]),
            .clr_i (clr_i[i]),
            .q_o   (q_o[i])
        );
    end

    assert_fault_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/flash_cmd_stat.sv
module flash_cmd_stat
    import flcs_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          ST_W       = 2,
    parameter logic [3:0]  STAT_ADDR  = 4'h6,
    parameter logic [3:0]  FAULT_ADDR = 4'h7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [ST_W-1:0]   eng_stat,
    input  logic              prot_viol,
    input  logic              fault_single,
    input  logic              fault_double
);
    localparam int N_FLT = 2;
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_FAULT = ADDR_W'(FAULT_ADDR);

    logic             wr_stat, wr_fault;
    logic             launch_req, blocked;
    logic             acc_q, prot_q, acc_set;
    logic             idle;
    logic [ST_W-1:0]  stat;
    logic [N_FLT-1:0] flt_q, flt_set, flt_clr;
    logic             unused_wbits;

    assign wr_stat    = reg_wr && (reg_addr == A_STAT);
    assign wr_fault   = reg_wr && (reg_addr == A_FAULT);
    assign launch_req = wr_stat && reg_wdata[BIT_DONE];
    assign blocked    = acc_q || prot_q;
    assign unused_wbits = ^{reg_wdata[6], reg_wdata[3:2], reg_wdata[7:2] & 6'h00};

    flcs_cmd_fsm #(.ST_W(ST_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_req_i (launch_req),
        .blocked_i    (blocked),
        .eng_done_i   (eng_done),
        .eng_err_i    (eng_err),
        .eng_stat_i   (eng_stat),
        .idle_o       (idle),
        .start_o      (eng_start),
        .acc_set_o    (acc_set),
        .stat_o       (stat)
    );

    flcs_w1c_flag u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (acc_set),
        .clr_i (wr_stat && reg_wdata[BIT_ACCER]),
        .q_o   (acc_q)
    );

    flcs_w1c_flag u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (prot_viol),
        .clr_i (wr_stat && reg_wdata[BIT_PROT]),
        .q_o   (prot_q)
    );

    assign flt_set = {fault_double, fault_single};
    assign flt_clr = {N_FLT{wr_fault}} & {reg_wdata[BIT_DFLT], reg_wdata[BIT_SFLT]};

    flcs_fault_reg #(.N_FLT(N_FLT)) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flt_set),
        .clr_i (flt_clr),
        .q_o   (flt_q)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STAT) begin
            reg_rdata[BIT_DONE]  = idle;
            reg_rdata[BIT_ACCER] = acc_q;
            reg_rdata[BIT_PROT]  = prot_q;
            reg_rdata[BIT_BUSY]  = !idle;
            reg_rdata[ST_W-1:0]  = stat;
        end else if (reg_addr == A_FAULT) begin
            reg_rdata[N_FLT-1:0] = flt_q;
        end
    end

    assert_engine_err_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && eng_err) |=> acc_q);
    assert_prot_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && launch_req) |=> !eng_start);
    assert_launch_clears_stat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (stat == '0));
endmodule

// File: tb/tb_flash_cmd_stat.sv
module tb_flash_cmd_stat;
    localparam int CLK_P = 10;
    localparam logic [3:0] AS = 4'h6;
    localparam logic [3:0] AF = 4'h7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = AS;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_start;
    logic       eng_done = 1'b0;
    logic       eng_err = 1'b0;
    logic [1:0] eng_stat = '0;
    logic       prot_viol = 1'b0;
    logic       fault_single = 1'b0;
    logic       fault_double = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp_data;
        logic       exp_start;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    flash_cmd_stat dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_done(eng_done), .eng_err(eng_err), .eng_stat(eng_stat),
        .prot_viol(prot_viol), .fault_single(fault_single), .fault_double(fault_double)
    );

    // Driver tasks: each starts and ends at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic eng_pulse(input bit done, input bit err, input logic [1:0] st);
        eng_done = done; eng_err = err; eng_stat = st;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_stat = '0;
    endtask

    task automatic in_pulse(input int which);
        if (which == 0) prot_viol = 1'b1;
        if (which == 1) fault_single = 1'b1;
        if (which == 2) fault_double = 1'b1;
        @(negedge clk);
        prot_viol = 1'b0; fault_single = 1'b0; fault_double = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [7:0] d,
                             input logic st, input string tag);
        item_t it;
        reg_addr = a;
        it.exp_data = d; it.exp_start = st; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: pops one expected item per falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (reg_rdata !== it.exp_data || eng_start !== it.exp_start) begin
                    bad++;
                    $display("FAIL %s: rdata=%02h start=%b expected rdata=%02h start=%b",
                             it.tag, reg_rdata, eng_start, it.exp_data, it.exp_start);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: stalled run, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_rd(AS, 8'h80, 1'b0, "R1 status reset");
        expect_rd(AF, 8'h00, 1'b0, "R1 fault reset");
        // R2 clean launch, then R3 finish with status 01
        wr(AS, 8'h80);
        expect_rd(AS, 8'h08, 1'b1, "R2 launch start pulse");
        expect_rd(AS, 8'h08, 1'b0, "R2 start one cycle R8 busy");
        eng_pulse(1'b1, 1'b0, 2'b01);
        expect_rd(AS, 8'h81, 1'b0, "R3 done status");
        // R2 relaunch clears status, R4 engine error
        wr(AS, 8'h80);
        expect_rd(AS, 8'h08, 1'b1, "R2 relaunch clears status");
        eng_pulse(1'b0, 1'b1, 2'b00);
        expect_rd(AS, 8'hA0, 1'b0, "R4 error sets access flag");
        // R5 blocked launch
        wr(AS, 8'h80);
        expect_rd(AS, 8'hA0, 1'b0, "R5 launch refused");
        // R7 zero write keeps flag, combined write clears but refuses
        wr(AS, 8'h00);
        expect_rd(AS, 8'hA0, 1'b0, "R7 write 0 no effect");
        wr(AS, 8'hA0);
        expect_rd(AS, 8'h80, 1'b0, "R7 combined write judged on old state");
        // R6 protection violation
        in_pulse(0);
        expect_rd(AS, 8'h90, 1'b0, "R6 prot flag set");
        wr(AS, 8'h80);
        expect_rd(AS, 8'h90, 1'b0, "R6 launch refused");
        wr(AS, 8'h10);
        expect_rd(AS, 8'h80, 1'b0, "R7 prot flag cleared");
        // R9 relaunch during run, then finish with status 11
        wr(AS, 8'h80);
        expect_rd(AS, 8'h08, 1'b1, "R2 launch after clear");
        wr(AS, 8'h80);
        expect_rd(AS, 8'h08, 1'b0, "R9 no second start");
        eng_pulse(1'b1, 1'b0, 2'b11);
        expect_rd(AS, 8'h83, 1'b0, "R3 done status 11");
        // R10 reserved and read-only bits
        wr(AS, 8'h4C);
        expect_rd(AS, 8'h83, 1'b0, "R10 reserved and status bits");
        wr(AS, 8'h80);
        expect_rd(AS, 8'h08, 1'b1, "R2 launch clears 11");
        eng_pulse(1'b1, 1'b0, 2'b00);
        expect_rd(AS, 8'h80, 1'b0, "R3 done status 00");
        // R9 done while idle
        eng_pulse(1'b1, 1'b0, 2'b11);
        expect_rd(AS, 8'h80, 1'b0, "R9 idle done ignored");
        // R11 fault register
        in_pulse(1);
        expect_rd(AF, 8'h01, 1'b0, "R11 single fault");
        in_pulse(2);
        expect_rd(AF, 8'h03, 1'b0, "R11 double fault");
        wr(AF, 8'hFC);
        expect_rd(AF, 8'h03, 1'b0, "R11 upper bits ignored");
        wr(AF, 8'h02);
        expect_rd(AF, 8'h01, 1'b0, "R11 clear double");
        wr(AF, 8'h01);
        expect_rd(AF, 8'h00, 1'b0, "R11 clear single");
        expect_rd(AS, 8'h80, 1'b0, "R8 idle not busy");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule